// File: doc/BRIEF.md
# Quarter-Rate Quadrature Mixer with Decimate-by-Two

This block takes a real, signed sample stream taken from an intermediate frequency and turns it into complex baseband I/Q pairs at half the input sample rate. The sample clock is chosen so that the IF sits at a quarter of the sampling rate, aliased down by an odd factor: Fs = 4·F_IF / n with n odd. Under that choice the local oscillator's cosine and sine collapse to repeating patterns built from 0, +1 and -1, so each mixer product is the sample, its negation, or nothing.

Every zero product is thrown away, which is the same as decimating each branch by two. Samples at even phases feed the in-phase branch and samples at odd phases feed the quadrature branch. A pair is emitted after each odd-phase sample, with a one-cycle strobe. The output words carry one extra bit, so negating the most negative input cannot wrap. Input samples arrive with a qualifying strobe. When the strobe is low, the phase stays where it is and nothing is emitted.

Top module: `iq_quarter_mixer`

## Requirements
- R1: While synchronous reset is high and on the cycle after it, out_valid is 0 and out_i and out_q are 0.
- R2: A valid sample x taken at phase 0 contributes +x as the I value of the next pair. One taken at phase 2 contributes -x.
- R3: A valid sample x taken at phase 1 becomes the Q value +x of the pair it completes. One taken at phase 3 gives Q = -x.
- R4: Outputs are IN_W+1 bits signed with sign extension. Negating the most negative input (-2^(IN_W-1)) gives +2^(IN_W-1) exactly, with no wrap.
- R5: out_valid goes high for exactly one cycle, in the cycle after each phase-1 or phase-3 valid sample. This gives one pair for every two valid samples, and out_valid is never high on two consecutive cycles.
- R6: A cycle with in_valid low leaves the phase unchanged. In the following cycle out_valid is 0 and out_i and out_q hold their previous values.
- R7: The phase starts at 0 after reset and steps 0→1→2→3→0 on each valid sample only. A reset in mid-stream drops any half-built pair.
- R8: An input tone at Fs/4 with zero phase (A, 0, -A, 0, …) yields I = A and Q = 0 on every pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_sample for this cycle |
| in_sample | input | IN_W | Signed real IF sample |
| out_valid | output | 1 | One-cycle strobe marking a new I/Q pair |
| out_i | output | IN_W+1 | Signed in-phase output |
| out_q | output | IN_W+1 | Signed quadrature output |

## Verification
The bench builds the block with IN_W = 8, so the full input code space is only 256 values. That makes it practical to push every code through every one of the four phases, and the most negative code -128 gets negated at both negating phases. With the narrow width, the +128 result that needs the ninth output bit shows up directly. The same setting keeps the Fs/4 tone and the ramp inside small, readable values, so any sign or pairing error can be seen in the printed expected and actual numbers.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

    typedef enum logic [1:0] {
        PH_I_POS = 2'd0,
        PH_Q_POS = 2'd1,
        PH_I_NEG = 2'd2,
        PH_Q_NEG = 2'd3
    } phase_e;

    // odd phases belong to the quadrature branch
    function automatic logic phase_is_q(phase_e p);
        return p[0];
    endfunction

    // the upper half of the cycle carries the -1 multiplier
    function automatic logic phase_is_neg(phase_e p);
        return p[1];
    endfunction

endpackage

// File: rtl/iqm_phase_ctr.sv
module iqm_phase_ctr
    import iqm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output phase_e phase
);

    typedef struct packed {
        phase_e ph;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.ph = phase_e'(st_q.ph + 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_I_POS};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

    // R7: each accepted sample moves the phase forward by one, wrapping mod 4
    assert_phase_advance_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> (phase == phase_e'($past(phase) + 2'd1)));

    // R6: a held-off cycle leaves the phase untouched
    assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(phase));

endmodule

// File: rtl/iqm_sign_sel.sv
module iqm_sign_sel #(
    parameter int IN_W = 12
) (
    input  logic signed [IN_W-1:0] x,
    input  logic                   negate,
    output logic signed [IN_W:0]   y
);

    localparam int OUT_W = IN_W + 1;

    logic signed [OUT_W-1:0] widened;

    always_comb begin
        widened = {x[IN_W-1], x};
        y       = negate ? -widened : widened;
    end

    // R4: a negated nonzero value always flips sign, so no wrap occurs
    always_comb begin
        if (negate && (widened != '0)) begin
            assert_no_overflow_R4: assert (y[OUT_W-1] != widened[OUT_W-1]);
        end
    end

endmodule

// File: rtl/iqm_pair_reg.sv
module iqm_pair_reg #(
    parameter int W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take_i,
    input  logic                take_q,
    input  logic signed [W-1:0] product,
    output logic                pair_valid,
    output logic signed [W-1:0] pair_i,
    output logic signed [W-1:0] pair_q
);

    typedef struct packed {
        logic [W-1:0] pend_i;
        logic [W-1:0] i;
        logic [W-1:0] q;
        logic         vld;
    } pair_state_t;

    pair_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (take_i) begin
            st_d.pend_i = product;
        end
        if (take_q) begin
            st_d.i   = st_q.pend_i;
            st_d.q   = product;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_valid = st_q.vld;
    assign pair_i     = st_q.i;
    assign pair_q     = st_q.q;

    // R5: a product goes to exactly one branch per cycle
    assert_one_branch_R5: assert property (@(posedge clk) disable iff (rst)
        !(take_i && take_q));

    // R6: without a quadrature product the presented pair is frozen
    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !take_q |=> ($stable(pair_i) && $stable(pair_q) && !pair_valid));

endmodule

// File: rtl/iq_quarter_mixer.sv
module iq_quarter_mixer
    import iqm_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                out_valid,
    output logic signed [IN_W:0] out_i,
    output logic signed [IN_W:0] out_q
);

    localparam int OUT_W = IN_W + 1;

    phase_e                  phase;
    logic                    to_q;
    logic                    flip;
    logic                    take_i;
    logic                    take_q;
    logic signed [OUT_W-1:0] product;

    iqm_phase_ctr u_phase (
        .clk   (clk),
        .rst   (rst),
        .step  (in_valid),
        .phase (phase)
    );

    always_comb begin
        to_q   = phase_is_q(phase);
        flip   = phase_is_neg(phase);
        take_i = in_valid && !to_q;
        take_q = in_valid && to_q;
    end

    iqm_sign_sel #(
        .IN_W (IN_W)
    ) u_sign (
        .x      (in_sample),
        .negate (flip),
        .y      (product)
    );

    iqm_pair_reg #(
        .W (OUT_W)
    ) u_pair (
        .clk        (clk),
        .rst        (rst),
        .take_i     (take_i),
        .take_q     (take_q),
        .product    (product),
        .pair_valid (out_valid),
        .pair_i     (out_i),
        .pair_q     (out_q)
    );

    // R5: the strobe is a single-cycle pulse
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5: an odd-phase sample always completes a pair
    assert_odd_emits_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && phase[0]) |=> out_valid);

    // R6: an idle input cycle never produces a pair
    assert_idle_silent_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_i == '0) && (out_q == '0)));

endmodule

// File: tb/iq_quarter_mixer_test.sv
module iq_quarter_mixer_test;

    localparam int IN_W  = 8;
    localparam int OUT_W = IN_W + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst;
    logic                    in_valid;
    logic signed [IN_W-1:0]  in_sample;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_i;
    logic signed [OUT_W-1:0] out_q;

    iq_quarter_mixer #(.IN_W(IN_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    bit done   = 1'b0;

    // reference model state
    int m_phase = 0;
    int m_pend  = 0;
    int m_i     = 0;
    int m_q     = 0;
    bit m_vld   = 1'b0;

    task automatic compare(string req);
        int ai;
        int aq;
        ai = out_i;
        aq = out_q;
        checks++;
        if (out_valid !== m_vld || ai != m_i || aq != m_q) begin
            errors++;
            $display("FAIL %s: valid=%0d i=%0d q=%0d expected valid=%0d i=%0d q=%0d",
                     req, out_valid, ai, aq, m_vld, m_i, m_q);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; drives one cycle and checks the result at the next falling edge
    task automatic step(bit v, int x, string req);
        in_valid  = v;
        in_sample = IN_W'(x);
        m_vld     = 1'b0;
        if (v) begin
            case (m_phase)
                0: m_pend = x;
                1: begin m_i = m_pend; m_q = x;  m_vld = 1'b1; end
                2: m_pend = -x;
                default: begin m_i = m_pend; m_q = -x; m_vld = 1'b1; end
            endcase
            m_phase = (m_phase + 1) % 4;
        end
        @(negedge clk);
        compare(req);
        if (out_valid) pulses++;
    endtask

    task automatic t_reset();
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_sample = '0;
        repeat (3) @(negedge clk);
        m_phase = 0; m_pend = 0; m_i = 0; m_q = 0; m_vld = 1'b0;
        compare("R1 during reset");
        rst = 1'b0;
        step(1'b0, 0, "R1 after reset");
    endtask

    task automatic t_ramp();
        pulses = 0;
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 3 * k - 20, "R2/R3 ramp");
        end
        check_int("R5 pairs per 16 samples", pulses, 8);
    endtask

    task automatic t_extremes();
        for (int k = 0; k < 4; k++) step(1'b1, -128, "R4 most negative");
        check_int("R4 negated I", out_i, 128);
        check_int("R4 negated Q", out_q, 128);
        for (int k = 0; k < 4; k++) step(1'b1, 127, "R4 most positive");
    endtask

    task automatic t_hold();
        step(1'b1, 40, "R6 gaps");
        step(1'b0, 99, "R6 idle after phase 0");
        step(1'b0, 98, "R6 idle after phase 0");
        step(1'b1, 50, "R6 gaps");
        step(1'b0, 97, "R6 idle keeps pair");
        step(1'b0, 96, "R6 idle keeps pair");
        step(1'b1, 60, "R6 gaps");
        step(1'b0, 95, "R6 idle after phase 2");
        step(1'b1, 70, "R6 gaps");
        check_int("R6 I after gaps", out_i, -60);
        check_int("R6 Q after gaps", out_q, -70);
    endtask

    task automatic t_cosine();
        for (int n = 0; n < 8; n++) begin
            step(1'b1, 100,  "R8 tone");
            step(1'b1, 0,    "R8 tone");
            check_int("R8 I constant", out_i, 100);
            check_int("R8 Q zero", out_q, 0);
            step(1'b1, -100, "R8 tone");
            step(1'b1, 0,    "R8 tone");
            check_int("R8 I constant", out_i, 100);
            check_int("R8 Q zero", out_q, 0);
        end
    endtask

    task automatic t_sweep();
        for (int p = 0; p < 4; p++) begin
            for (int v = -128; v < 128; v++) begin
                step(1'b1, v, "R2/R3/R4 sweep");
            end
            step(1'b1, 5, "R7 phase shift");
        end
    endtask

    task automatic t_midreset();
        step(1'b1, 5, "R7 pre-reset");
        step(1'b1, 7, "R7 pre-reset");
        step(1'b1, 9, "R7 pre-reset");
        t_reset();
        step(1'b1, 11, "R7 restart at phase 0");
        step(1'b1, 13, "R7 restart at phase 0");
        check_int("R7 I after reset", out_i, 11);
        check_int("R7 Q after reset", out_q, 13);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ramp();
        t_extremes();
        t_hold();
        t_cosine();
        t_sweep();
        t_midreset();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule